// File: doc/BRIEF.md
# Steering Target Resolver

The resolver takes the offset of a replicated register and decides which steering class, if any, governs it. Each class owns a small set of inclusive address windows held in a built-in table. When a request is accepted, the table is walked one window per clock, in class-priority order. The first window that contains the offset decides the class. The walk stops at that window, or after the last window when nothing matches.

For the deciding class, the block derives a group and instance pair from the fuse and enable masks so that the pair is sure to address a live unit:

- **L3-bank windows** use the lowest enabled bank.
- **Memory-slice windows** use the lowest present slice.
- **Cache-node windows** use twice the lowest present slice.
- **Subslice windows** split the first enabled subslice ID into a group and an instance.

An offset outside every window falls back to a default pair supplied on input pins.

A parameter removes whole classes from the table, so a configuration that lacks a class does not spend cycles on its windows. The result is held on registered outputs until the next request completes, and a one-cycle done pulse marks each new result.

Top module: `steer_resolver`

## Requirements
- R1: A window matches when lo <= offset <= hi. Both end addresses of a window match, and the addresses just outside it do not. Built-in windows, in scan order:
  - L3-bank: 0x0B100-0x0B3FF
  - Memory-slice: 0x0DD00-0x0DDFF and 0x0E800-0x0FFFF
  - Cache-node: 0x0B000-0x0B0FF and 0x0D880-0x0D8FF
  - Subslice: 0x05200-0x052FF, 0x05500-0x07FFF and 0x0DE80-0x0E8FF
- R2: Classes are scanned in the priority order L3-bank, memory-slice, cache-node, subslice, and the first matching window wins. An offset in 0x0E800-0x0E8FF therefore resolves to memory-slice, not subslice.
- R3: `hit_cls` encodes the class as L3-bank=0, memory-slice=1, cache-node=2, subslice=3, none=7. When no window matches, `hit_cls` is 7 and the group/instance are the `dflt_grp`/`dflt_inst` values sampled at acceptance.
- R4: The L3-bank class returns group 0 and, as instance, the index of the lowest enabled bank. Fuse bit i enables banks 2i and 2i+1. With no bank enabled, the instance is 0.
- R5: The memory-slice class returns, as group, the index of the lowest present slice, with instance 0. Slice s is present when `meml3_en[s]` is set or any of `ss_en[4s+3:4s]` is set. With no slice present, the group is 0.
- R6: The cache-node class returns twice the lowest present slice index as group, with instance 0.
- R7: The subslice class takes the lowest set bit d of `ss_en` and returns group d/4 and instance d%4. With no subslice enabled, d is 0.
- R8: `done` is a one-cycle pulse. It rises p+1 clocks after the accepting edge when the p-th scanned window (counting from 0) decides the request, and N clocks after it on a miss, where N is the number of windows in the table.
- R9: `req_valid` is ignored while a request is being scanned. Offset and mask changes during the scan do not alter its result.
- R10: A class disabled by `CLS_EN` contributes no windows and takes no scan cycles. Its offsets resolve to the next matching class or to the default.
- R11: After reset, `done`=0, `hit_cls`=7, and the group and instance are 0.
- R12: The outputs hold their values in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a lookup (accepted when idle) |
| req_ofs | input | OFS_W | Register offset to classify |
| l3_fuse | input | L3_FUSE_W | L3 enable field, one bit per bank pair |
| meml3_en | input | SLICES | Per-slice memory-L3 enable |
| ss_en | input | SLICES*SS_PER_SLICE | Subslice enable mask |
| dflt_grp | input | GRP_W | Default group for unmatched offsets |
| dflt_inst | input | INST_W | Default instance for unmatched offsets |
| hit_cls | output | 3 | Resolved class code |
| tgt_grp | output | GRP_W | Resolved group |
| tgt_inst | output | INST_W | Resolved instance |
| done | output | 1 | One-cycle result strobe |

## Verification
The following properties are checked on every clock:

- `done` is a single-cycle pulse, never later than the table length after acceptance.
- The outputs stay frozen between pulses.
- The per-class invariants hold: group 0 for L3-bank, an even group for cache-node, and an instance below four for subslice.

Only the bench scenarios can show the rest:

- The exact window chosen at range boundaries.
- Priority between overlapping windows.
- Each class's fuse-derived target value.
- The precise latency per window position.
- That requests and mask changes during a scan are ignored.
- That a disabled class is skipped.

// File: rtl/steer_pkg.sv
package steer_pkg;

  localparam int NUM_CLS    = 4;
  localparam int RNG_W      = 24;
  localparam int NUM_RANGES = 8;

  typedef enum logic [2:0] {
    CLS_L3BANK   = 3'd0,
    CLS_MSLICE   = 3'd1,
    CLS_NODE     = 3'd2,
    CLS_SUBSLICE = 3'd3,
    CLS_DEFAULT  = 3'd7
  } steer_cls_e;

  typedef struct packed {
    steer_cls_e       cls;
    logic [RNG_W-1:0] lo;
    logic [RNG_W-1:0] hi;
  } steer_rng_t;

  // Built-in window list, already sorted by class priority.
  function automatic steer_rng_t rng_at(int i);
    steer_rng_t r;
    case (i)
      0:       r = '{cls: CLS_L3BANK,   lo: 24'h00B100, hi: 24'h00B3FF};
      1:       r = '{cls: CLS_MSLICE,   lo: 24'h00DD00, hi: 24'h00DDFF};
      2:       r = '{cls: CLS_MSLICE,   lo: 24'h00E800, hi: 24'h00FFFF};
      3:       r = '{cls: CLS_NODE,     lo: 24'h00B000, hi: 24'h00B0FF};
      4:       r = '{cls: CLS_NODE,     lo: 24'h00D880, hi: 24'h00D8FF};
      5:       r = '{cls: CLS_SUBSLICE, lo: 24'h005200, hi: 24'h0052FF};
      6:       r = '{cls: CLS_SUBSLICE, lo: 24'h005500, hi: 24'h007FFF};
      default: r = '{cls: CLS_SUBSLICE, lo: 24'h00DE80, hi: 24'h00E8FF};
    endcase
    return r;
  endfunction

  function automatic bit rng_enabled(logic [NUM_CLS-1:0] en, int i);
    steer_rng_t r;
    r = rng_at(i);
    return en[int'(r.cls)];
  endfunction

  // Number of windows that survive the class enable mask.
  function automatic int active_count(logic [NUM_CLS-1:0] en);
    int n;
    n = 0;
    for (int i = 0; i < NUM_RANGES; i++)
      if (rng_enabled(en, i)) n++;
    return n;
  endfunction

  // Source index of the k-th surviving window.
  function automatic int active_nth(logic [NUM_CLS-1:0] en, int k);
    int n;
    int src;
    n = 0;
    src = 0;
    for (int i = 0; i < NUM_RANGES; i++) begin
      if (rng_enabled(en, i)) begin
        if (n == k) src = i;
        n++;
      end
    end
    return src;
  endfunction

endpackage

// File: rtl/steer_lowbit.sv
module steer_lowbit #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);

  // Scan from the top so the lowest set bit is the last assignment.
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--)
      if (vec[i]) idx = IW'(i);
  end

endmodule

// File: rtl/steer_fuse_decode.sv
module steer_fuse_decode #(
  parameter int L3_FUSE_W    = 3,
  parameter int SLICES       = 4,
  parameter int SS_PER_SLICE = 4,
  parameter int BANK_IW      = $clog2(2 * L3_FUSE_W),
  parameter int SLICE_IW     = (SLICES > 1) ? $clog2(SLICES) : 1,
  parameter int SS_IW        = $clog2(SLICES * SS_PER_SLICE)
) (
  input  logic [L3_FUSE_W-1:0]           l3_fuse,
  input  logic [SLICES-1:0]              meml3_en,
  input  logic [SLICES*SS_PER_SLICE-1:0] ss_en,
  output logic [BANK_IW-1:0]             bank_idx,
  output logic [SLICE_IW-1:0]            slice_idx,
  output logic [SS_IW-1:0]               ss_idx
);

  localparam int BANKS    = 2 * L3_FUSE_W;
  localparam int SS_TOTAL = SLICES * SS_PER_SLICE;

  logic [BANKS-1:0]  bank_mask;
  logic [SLICES-1:0] slice_live;

  // Each fuse bit enables a pair of adjacent banks.
  for (genvar i = 0; i < L3_FUSE_W; i++) begin : g_bank
    assign bank_mask[2*i+1:2*i] = {2{l3_fuse[i]}};
  end

  // A slice is live with its memory-L3 or any subslice in its quadrant.
  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    assign slice_live[s] = meml3_en[s] | (|ss_en[s*SS_PER_SLICE +: SS_PER_SLICE]);
  end

  steer_lowbit #(.W(BANKS),    .IW(BANK_IW))  u_bank  (.vec(bank_mask),  .idx(bank_idx));
  steer_lowbit #(.W(SLICES),   .IW(SLICE_IW)) u_slice (.vec(slice_live), .idx(slice_idx));
  steer_lowbit #(.W(SS_TOTAL), .IW(SS_IW))    u_ss    (.vec(ss_en),      .idx(ss_idx));

endmodule

// File: rtl/steer_range_scan.sv
module steer_range_scan
  import steer_pkg::*;
#(
  parameter int                 OFS_W  = RNG_W,
  parameter logic [NUM_CLS-1:0] CLS_EN = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OFS_W-1:0] ofs,
  output logic             busy,
  output logic             finish,
  output logic             hit,
  output steer_cls_e       hit_cls
);

  localparam int N_ACT = active_count(CLS_EN);
  localparam int N_TBL = (N_ACT > 0) ? N_ACT : 1;
  localparam int IDX_W = (N_TBL > 1) ? $clog2(N_TBL) : 1;

  steer_rng_t       tbl [N_TBL];
  steer_rng_t       cur;
  logic [IDX_W-1:0] idx;
  logic [OFS_W-1:0] ofs_q;
  logic             last;

  // Compacted window table: only classes enabled by CLS_EN.
  for (genvar g = 0; g < N_TBL; g++) begin : g_tbl
    localparam int SRC = (N_ACT > 0) ? active_nth(CLS_EN, g) : 0;
    assign tbl[g] = rng_at(SRC);
  end

  assign cur     = tbl[idx];
  assign last    = (idx == IDX_W'(N_TBL - 1));
  assign hit     = busy && (N_ACT > 0) &&
                   (ofs_q >= OFS_W'(cur.lo)) && (ofs_q <= OFS_W'(cur.hi));
  assign hit_cls = cur.cls;
  assign finish  = busy && (hit || last);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      idx   <= '0;
      ofs_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        idx   <= '0;
        ofs_q <= ofs;
      end
    end else if (finish) begin
      busy <= 1'b0;
    end else begin
      idx <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/steer_resolver.sv
module steer_resolver
  import steer_pkg::*;
#(
  parameter int                 OFS_W        = RNG_W,
  parameter int                 L3_FUSE_W    = 3,
  parameter int                 SLICES       = 4,
  parameter int                 SS_PER_SLICE = 4,
  parameter int                 SS_PER_GRP   = 4,
  parameter int                 GRP_W        = 4,
  parameter int                 INST_W       = 4,
  parameter logic [NUM_CLS-1:0] CLS_EN       = '1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  input  logic [OFS_W-1:0]               req_ofs,
  input  logic [L3_FUSE_W-1:0]           l3_fuse,
  input  logic [SLICES-1:0]              meml3_en,
  input  logic [SLICES*SS_PER_SLICE-1:0] ss_en,
  input  logic [GRP_W-1:0]               dflt_grp,
  input  logic [INST_W-1:0]              dflt_inst,
  output logic [2:0]                     hit_cls,
  output logic [GRP_W-1:0]               tgt_grp,
  output logic [INST_W-1:0]              tgt_inst,
  output logic                           done
);

  localparam int SS_TOTAL = SLICES * SS_PER_SLICE;
  localparam int BANK_IW  = $clog2(2 * L3_FUSE_W);
  localparam int SLICE_IW = (SLICES > 1) ? $clog2(SLICES) : 1;
  localparam int SS_IW    = $clog2(SS_TOTAL);

  logic                 busy, finish, hit;
  steer_cls_e           scan_cls;
  logic [L3_FUSE_W-1:0] l3_q;
  logic [SLICES-1:0]    meml3_q;
  logic [SS_TOTAL-1:0]  ss_q;
  logic [GRP_W-1:0]     dgrp_q;
  logic [INST_W-1:0]    dinst_q;
  logic [BANK_IW-1:0]   bank_idx;
  logic [SLICE_IW-1:0]  slice_idx;
  logic [SS_IW-1:0]     ss_idx;
  steer_cls_e           nxt_cls;
  logic [GRP_W-1:0]     nxt_grp;
  logic [INST_W-1:0]    nxt_inst;

  steer_range_scan #(.OFS_W(OFS_W), .CLS_EN(CLS_EN)) u_scan (
    .clk     (clk),
    .rst     (rst),
    .start   (req_valid),
    .ofs     (req_ofs),
    .busy    (busy),
    .finish  (finish),
    .hit     (hit),
    .hit_cls (scan_cls)
  );

  // Masks are frozen at acceptance so the scan sees one consistent set.
  always_ff @(posedge clk) begin
    if (rst) begin
      l3_q    <= '0;
      meml3_q <= '0;
      ss_q    <= '0;
      dgrp_q  <= '0;
      dinst_q <= '0;
    end else if (req_valid && !busy) begin
      l3_q    <= l3_fuse;
      meml3_q <= meml3_en;
      ss_q    <= ss_en;
      dgrp_q  <= dflt_grp;
      dinst_q <= dflt_inst;
    end
  end

  steer_fuse_decode #(
    .L3_FUSE_W    (L3_FUSE_W),
    .SLICES       (SLICES),
    .SS_PER_SLICE (SS_PER_SLICE),
    .BANK_IW      (BANK_IW),
    .SLICE_IW     (SLICE_IW),
    .SS_IW        (SS_IW)
  ) u_fuse (
    .l3_fuse   (l3_q),
    .meml3_en  (meml3_q),
    .ss_en     (ss_q),
    .bank_idx  (bank_idx),
    .slice_idx (slice_idx),
    .ss_idx    (ss_idx)
  );

  // Per-class target rule.
  always_comb begin
    nxt_cls  = hit ? scan_cls : CLS_DEFAULT;
    nxt_grp  = dgrp_q;
    nxt_inst = dinst_q;
    if (hit) begin
      case (scan_cls)
        CLS_L3BANK: begin
          nxt_grp  = '0;
          nxt_inst = INST_W'(bank_idx);
        end
        CLS_MSLICE: begin
          nxt_grp  = GRP_W'(slice_idx);
          nxt_inst = '0;
        end
        CLS_NODE: begin
          nxt_grp  = GRP_W'({slice_idx, 1'b0});
          nxt_inst = '0;
        end
        CLS_SUBSLICE: begin
          nxt_grp  = GRP_W'(int'(ss_idx) / SS_PER_GRP);
          nxt_inst = INST_W'(int'(ss_idx) % SS_PER_GRP);
        end
        default: begin
          nxt_grp  = dgrp_q;
          nxt_inst = dinst_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_cls  <= 3'(CLS_DEFAULT);
      tgt_grp  <= '0;
      tgt_inst <= '0;
      done     <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        hit_cls  <= 3'(nxt_cls);
        tgt_grp  <= nxt_grp;
        tgt_inst <= nxt_inst;
      end
    end
  end

endmodule

// File: rtl/steer_resolver_chk.sv
module steer_resolver_chk
  import steer_pkg::*;
#(
  parameter int                 GRP_W      = 4,
  parameter int                 INST_W     = 4,
  parameter int                 SS_PER_GRP = 4,
  parameter logic [NUM_CLS-1:0] CLS_EN     = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [2:0]        hit_cls,
  input logic [GRP_W-1:0]  tgt_grp,
  input logic [INST_W-1:0] tgt_inst,
  input logic              done
);

  localparam int MAX_LAT = active_count(CLS_EN);

  logic        pend;
  logic [15:0] cnt;

  // Independent view of the request in flight, taken from the ports.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      cnt  <= '0;
    end else if (req_valid && (!pend || done)) begin
      pend <= 1'b1;
      cnt  <= '0;
    end else begin
      if (done) pend <= 1'b0;
      if (pend) cnt <= cnt + 1'b1;
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_has_req_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> pend);

  assert_latency_bound_R8: assert property (@(posedge clk) disable iff (rst)
    pend |-> (cnt <= 16'(MAX_LAT)));

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(hit_cls) && $stable(tgt_grp) && $stable(tgt_inst)));

  assert_l3_group_R4: assert property (@(posedge clk) disable iff (rst)
    (done && hit_cls == 3'd0) |-> (tgt_grp == '0));

  assert_node_even_R6: assert property (@(posedge clk) disable iff (rst)
    (done && hit_cls == 3'd2) |-> (tgt_grp[0] == 1'b0 && tgt_inst == '0));

  assert_ss_inst_R7: assert property (@(posedge clk) disable iff (rst)
    (done && hit_cls == 3'd3) |-> (int'(tgt_inst) < SS_PER_GRP));

  assert_cls_code_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (hit_cls <= 3'd3 || hit_cls == 3'd7));

endmodule

bind steer_resolver steer_resolver_chk #(
  .GRP_W      (GRP_W),
  .INST_W     (INST_W),
  .SS_PER_GRP (SS_PER_GRP),
  .CLS_EN     (CLS_EN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .hit_cls   (hit_cls),
  .tgt_grp   (tgt_grp),
  .tgt_inst  (tgt_inst),
  .done      (done)
);

// File: tb/tb_steer_resolver.sv
module tb_steer_resolver;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_a = 1'b0, valid_b = 1'b0;
  logic [23:0] ofs = '0;
  logic [2:0]  l3 = '0;
  logic [3:0]  meml3 = '0;
  logic [15:0] ss = '0;
  logic [3:0]  dg = 4'd5, di = 4'd3;
  logic [2:0]  cls_a, cls_b;
  logic [3:0]  grp_a, grp_b, inst_a, inst_b;
  logic        done_a, done_b;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  steer_resolver dut (
    .clk(clk), .rst(rst), .req_valid(valid_a), .req_ofs(ofs), .l3_fuse(l3),
    .meml3_en(meml3), .ss_en(ss), .dflt_grp(dg), .dflt_inst(di),
    .hit_cls(cls_a), .tgt_grp(grp_a), .tgt_inst(inst_a), .done(done_a));

  // Memory-slice class removed.
  steer_resolver #(.CLS_EN(4'b1101)) dut_sk (
    .clk(clk), .rst(rst), .req_valid(valid_b), .req_ofs(ofs), .l3_fuse(l3),
    .meml3_en(meml3), .ss_en(ss), .dflt_grp(dg), .dflt_inst(di),
    .hit_cls(cls_b), .tgt_grp(grp_b), .tgt_inst(inst_b), .done(done_b));

  // Reference window list and class codes, from the requirements.
  int rlo [8] = '{'h0B100, 'h0DD00, 'h0E800, 'h0B000, 'h0D880, 'h05200, 'h05500, 'h0DE80};
  int rhi [8] = '{'h0B3FF, 'h0DDFF, 'h0FFFF, 'h0B0FF, 'h0D8FF, 'h052FF, 'h07FFF, 'h0E8FF};
  int rcl [8] = '{0, 1, 1, 2, 2, 3, 3, 3};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic predict(input bit skip_ms, output int ecls, output int egrp,
                         output int einst, output int elat);
    int pos = 0;
    int slice = 0;
    int bank = 0;
    int d = 0;
    bit found;
    ecls = 7;
    egrp = int'(dg);
    einst = int'(di);
    elat = -1;
    found = 0;
    for (int b = 5; b >= 0; b--) if (l3[b/2]) bank = b;
    for (int s = 3; s >= 0; s--) if (meml3[s] || ss[4*s +: 4] != 0) slice = s;
    for (int k = 15; k >= 0; k--) if (ss[k]) d = k;
    for (int i = 0; i < 8; i++) begin
      if (skip_ms && rcl[i] == 1) continue;
      if (!found && int'(ofs) >= rlo[i] && int'(ofs) <= rhi[i]) begin
        found = 1;
        elat = pos + 1;
        ecls = rcl[i];
        case (rcl[i])
          0: begin egrp = 0;         einst = bank;  end
          1: begin egrp = slice;     einst = 0;     end
          2: begin egrp = 2 * slice; einst = 0;     end
          default: begin egrp = d / 4; einst = d % 4; end
        endcase
      end
      pos++;
    end
    if (!found) elat = pos;
  endtask

  // One lookup, compared on every clock until one cycle past done.
  task automatic run(input string req, input bit sk, input logic [23:0] o, input bit jam);
    int ecls, egrp, einst, elat;
    logic [23:0] o_save;
    logic [2:0]  l3_save;
    @(negedge clk);
    ofs = o;
    predict(sk, ecls, egrp, einst, elat);
    if (sk) valid_b = 1'b1; else valid_a = 1'b1;
    @(posedge clk);
    @(negedge clk);
    valid_a = 1'b0;
    valid_b = 1'b0;
    o_save = ofs;
    l3_save = l3;
    if (jam && elat >= 2) begin
      // R9: noise on the request inputs while the scan runs
      valid_a = !sk;
      valid_b = sk;
      ofs = 24'h00B100;
      l3 = ~l3;
    end
    for (int k = 1; k <= elat; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (jam && k == elat - 1) begin
        valid_a = 1'b0;
        valid_b = 1'b0;
        ofs = o_save;
        l3 = l3_save;
      end
      chk({req, " R8 done timing"}, int'(sk ? done_b : done_a), int'(k == elat));
    end
    chk({req, " class"}, int'(sk ? cls_b : cls_a), ecls);
    chk({req, " group"}, int'(sk ? grp_b : grp_a), egrp);
    chk({req, " instance"}, int'(sk ? inst_b : inst_a), einst);
    @(posedge clk);
    @(negedge clk);
    chk({req, " R8 pulse width"}, int'(sk ? done_b : done_a), 0);
    chk({req, " R12 hold"}, int'(sk ? cls_b : cls_a), ecls);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 done", int'(done_a), 0);
    chk("R11 class", int'(cls_a), 7);
    chk("R11 group", int'(grp_a), 0);
    chk("R11 instance", int'(inst_a), 0);

    l3 = 3'b010; meml3 = 4'b0001; ss = 16'h0640;
    run("R1 R4 low edge", 0, 24'h00B100, 0);
    run("R1 R4 high edge", 0, 24'h00B3FF, 0);
    run("R1 R3 above window", 0, 24'h00B400, 0);
    run("R1 R3 below window", 0, 24'h0051FF, 0);
    run("R1 node end", 0, 24'h00B0FF, 0);
    run("R2 overlap", 0, 24'h00E850, 0);
    run("R7 last window", 0, 24'h00E7FF, 0);

    l3 = 3'b100; meml3 = 4'b0000; ss = 16'h0640;
    run("R6 node shift", 0, 24'h00D8C0, 0);
    run("R5 quadrant", 0, 24'h00DD00, 0);
    run("R4 upper bank", 0, 24'h00B200, 0);

    l3 = 3'b000; meml3 = 4'b0100; ss = 16'h8000;
    run("R7 top subslice", 0, 24'h005200, 0);
    run("R5 meml3 slice", 0, 24'h00FFFF, 0);
    run("R4 zero mask", 0, 24'h00B180, 0);

    l3 = 3'b010; meml3 = 4'b0001; ss = 16'h0640; dg = 4'd9; di = 4'd1;
    run("R9 busy ignore", 0, 24'h00B0FF, 1);
    run("R9 busy ignore miss", 0, 24'h00C000, 1);
    run("R10 skipped class", 1, 24'h00E850, 0);
    run("R10 skipped miss", 1, 24'h00DD80, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule